// File: doc/BRIEF.md
# Cartridge Bank Switching Controller

This block sits between a 16-bit CPU bus and a plug-in cartridge. It owns the 8 KB window at addresses 0x6000 to 0x7FFF and serves reads there from a 16 KB ROM image, or from 4 KB of on-cartridge RAM. It treats writes into that window in one of three ways, chosen by a static cartridge-type setting:

- as bank selections,
- as RAM stores,
- as illegal writes to ROM, which are dropped.

The bank is chosen by the address a write lands on. The data written plays no part. Address bit 1 of any write into the ROM window loads the one-bit bank latch.

The type setting decides how the window behaves:

- **Fully banked:** the whole window follows the bank latch.
- **Half-banked:** only the upper 4 KB follows the latch. The lower half always reads bank 0.
- **RAM cartridge:** the upper 4 KB is RAM and the lower 4 KB is one fixed ROM page.

A cartridge type without ROM leaves the window unclaimed.

The ROM side receives a 14-bit byte address, formed as `{bank, cpu_addr[12:0]}`, and returns a 16-bit word in the same cycle. CPU read data and the ready strobe are registered. Both appear one clock after the strobe.

Top module: `cart_bank_ctrl`

## Requirements
- R1: An access (cpu_rd or cpu_wr) is claimed when cpu_addr[15:13] is 3'b011 and type bit 0 (ROM present) is set. A claimed access raises cpu_ready for exactly the following cycle. An access outside the window never raises cpu_ready, and cpu_rdata then shows the float value 16'hFFFF.
- R2: With type bit 0 clear, the window is unclaimed. Reads give no ready and return 16'hFFFF. Writes give no ready and leave illegal_wr low.
- R3: In banked mode (type bit 2 set, type bit 1 clear), a write to the window loads the bank latch with cpu_addr[1]. The data value is ignored, and a word write acts exactly like a byte write.
- R4: After reset, the bank latch is 0 and illegal_wr is 0.
- R5: A read issued in the same cycle as a bank-switching write returns data from the bank held before that write.
- R6: In fully banked mode (type 4'b0101), every window address reads ROM byte address {bank, cpu_addr[12:0]}.
- R7: In half-banked mode (type bit 3 set as well, type 4'b1101), the lower half (cpu_addr[12]=0) reads with bank bit 0. The upper half uses the latch. Writes to either half still switch the bank.
- R8: In RAM mode (type bit 1 set), 0x7000 to 0x7FFF is read/write RAM.
  - A word write stores all 16 bits.
  - A byte write stores cpu_wdata[7:0] into the high byte at an even address and into the low byte at an odd address.
  - Reads return the whole word.
- R9: In RAM mode, 0x6000 to 0x6FFF reads ROM with bank bit 0 whatever the other type bits say. Writes there change nothing and set illegal_wr.
- R10: With ROM present and neither banked nor RAM set (type 4'b0001), writes to the window change no bank and set illegal_wr. The flag stays set until reset.
- R11: cpu_rdata and cpu_ready change only on the clock edge after the strobe. A cycle without a strobe gives cpu_ready low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cart_type | input | 4 | Static type: bit0 ROM, bit1 RAM, bit2 banked, bit3 half-banked |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 16 | CPU write data (byte writes use bits 7:0) |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_byte | input | 1 | 1 = byte write, 0 = word write |
| cpu_rdata | output | 16 | Registered read data |
| cpu_ready | output | 1 | Registered ready, one cycle after a claimed access |
| rom_addr | output | 14 | ROM byte address {bank, offset} |
| rom_rdata | input | 16 | ROM word at rom_addr, same cycle |
| illegal_wr | output | 1 | Sticky flag for writes aimed at fixed ROM |

## Verification
The bench builds the block with its default parameters:

- a 16-bit bus,
- a 13-bit window offset, which places the window tag 3'b011 at 0x6000,
- 2048 words of RAM,
- a float value of 16'hFFFF.

The bench's ROM model echoes the address it receives, so every read shows which bank bit the decoder produced. These values put both window edges within reach, along with the lower/upper half split at bit 12 and the last RAM word at 0x7FFE. Each cartridge type is applied after a fresh reset, so the bank latch and the sticky flag start from a known state in every scenario.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int TY_ROM  = 0;
  localparam int TY_RAM  = 1;
  localparam int TY_BANK = 2;
  localparam int TY_HALF = 3;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_ROM  = 2'd1,
    RG_RAM  = 2'd2
  } region_e;
endpackage

// File: rtl/cart_decode.sv
module cart_decode
  import cart_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 13,
  parameter logic [ADDR_W-WIN_AW-1:0] WIN_TAG = 3'b011
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        ctype,
  input  logic              bank_q,
  output region_e           region,
  output logic              wr_switch,
  output logic              wr_bad,
  output logic [WIN_AW:0]   rom_addr
);
  logic in_win;
  logic upper;
  logic bank_bit;

  assign in_win = (addr[ADDR_W-1:WIN_AW] == WIN_TAG);
  assign upper  = addr[WIN_AW-1];

  always_comb begin
    region = RG_NONE;
    if (in_win && ctype[TY_ROM]) begin
      if (ctype[TY_RAM] && upper) region = RG_RAM;
      else                        region = RG_ROM;
    end
  end

  // RAM cartridges carry one fixed ROM page; banked carts may pin the lower half
  always_comb begin
    bank_bit = 1'b0;
    if (!ctype[TY_RAM] && ctype[TY_BANK]) begin
      if (ctype[TY_HALF] && !upper) bank_bit = 1'b0;
      else                          bank_bit = bank_q;
    end
  end

  assign wr_switch = (region == RG_ROM) && ctype[TY_BANK] && !ctype[TY_RAM];
  assign wr_bad    = (region == RG_ROM) && !wr_switch;
  assign rom_addr  = {bank_bit, addr[WIN_AW-1:0]};
endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch #(
  parameter int SEL_BIT = 1,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              do_switch,
  input  logic              do_flag,
  input  logic [ADDR_W-1:0] addr,
  output logic              bank_q,
  output logic              bad_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (wr) begin
      if (do_switch) bank_q <= addr[SEL_BIT];
      if (do_flag)   bad_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/cart_ram.sv
module cart_ram #(
  parameter int WORDS  = 2048,
  parameter int LANES  = 2,
  localparam int IDX_W = $clog2(WORDS),
  localparam int DW    = 8 * LANES
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && be[l]) mem[idx] <= wdata[l*8 +: 8];
      rdata[l*8 +: 8] <= mem[idx];
    end
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int WIN_AW   = 13,
  parameter int BANK_BIT = 1,
  parameter logic [ADDR_W-WIN_AW-1:0] WIN_TAG = 3'b011,
  parameter logic [DATA_W-1:0] FLOAT_VAL = 16'hFFFF,
  localparam int ROM_AW    = WIN_AW + 1,
  localparam int RAM_WORDS = 2 ** (WIN_AW - 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cart_type,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_byte,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              illegal_wr
);
  region_e     region;
  logic        wr_switch, wr_bad, bank_q;
  logic [1:0]  be;
  logic [DATA_W-1:0] ram_wd, ram_q;
  logic [DATA_W-1:0] rom_q;
  logic        rd_hit_q;
  region_e     sel_q;

  cart_decode #(
    .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .WIN_TAG(WIN_TAG)
  ) u_dec (
    .addr(cpu_addr), .ctype(cart_type), .bank_q(bank_q),
    .region(region), .wr_switch(wr_switch), .wr_bad(wr_bad),
    .rom_addr(rom_addr)
  );

  cart_bank_latch #(.SEL_BIT(BANK_BIT), .ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst(rst), .wr(cpu_wr),
    .do_switch(wr_switch), .do_flag(wr_bad), .addr(cpu_addr),
    .bank_q(bank_q), .bad_q(illegal_wr)
  );

  // Big-endian lanes: even byte address is the high byte
  assign be     = cpu_byte ? (cpu_addr[0] ? 2'b01 : 2'b10) : 2'b11;
  assign ram_wd = cpu_byte ? {2{cpu_wdata[7:0]}} : cpu_wdata;

  cart_ram #(.WORDS(RAM_WORDS), .LANES(DATA_W / 8)) u_ram (
    .clk(clk), .we(cpu_wr && (region == RG_RAM)), .be(be),
    .idx(cpu_addr[WIN_AW-2:1]), .wdata(ram_wd), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ready <= 1'b0;
      rd_hit_q  <= 1'b0;
      sel_q     <= RG_NONE;
      rom_q     <= '0;
    end else begin
      cpu_ready <= (cpu_rd || cpu_wr) && (region != RG_NONE);
      rd_hit_q  <= cpu_rd && (region != RG_NONE);
      sel_q     <= region;
      rom_q     <= rom_rdata;
    end
  end

  always_comb begin
    if (!rd_hit_q)            cpu_rdata = FLOAT_VAL;
    else if (sel_q == RG_RAM) cpu_rdata = ram_q;
    else                      cpu_rdata = rom_q;
  end
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WIN_AW = 13,
  parameter int BANK_BIT = 1,
  parameter logic [ADDR_W-WIN_AW-1:0] WIN_TAG = 3'b011,
  parameter logic [DATA_W-1:0] FLOAT_VAL = 16'hFFFF
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cart_type,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_ready,
  input logic [WIN_AW:0]   rom_addr,
  input logic              illegal_wr
);
  logic win;
  assign win = (cpu_addr[ADDR_W-1:WIN_AW] == WIN_TAG);

  a_r1_claim_ready: assert property (@(posedge clk) disable iff (rst)
    ((cpu_rd || cpu_wr) && win && cart_type[0]) |=> cpu_ready);

  a_r2_float_read: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cart_type[0]) |=> (cpu_rdata == FLOAT_VAL && !cpu_ready));

  a_r2_no_flag: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cart_type[0] && !illegal_wr) |=> !illegal_wr);

  a_r6_bank_follows: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && win && cart_type == 4'b0101) |=>
      (win |-> rom_addr[WIN_AW] == $past(cpu_addr[BANK_BIT])));

  a_r7_low_half_fixed: assert property (@(posedge clk) disable iff (rst)
    (win && !cpu_addr[WIN_AW-1] && cart_type == 4'b1101) |-> !rom_addr[WIN_AW]);

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    illegal_wr |=> illegal_wr);

  a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && win && cart_type == 4'b0001) |=> illegal_wr);

  a_r11_idle_no_ready: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |=> !cpu_ready);
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW),
  .BANK_BIT(BANK_BIT), .WIN_TAG(WIN_TAG), .FLOAT_VAL(FLOAT_VAL)
) chk_i (
  .clk(clk), .rst(rst), .cart_type(cart_type), .cpu_addr(cpu_addr),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
  .cpu_ready(cpu_ready), .rom_addr(rom_addr), .illegal_wr(illegal_wr)
);

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cart_type = 4'b0000;
  logic [15:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_byte = 1'b0;
  logic [15:0] cpu_rdata;
  logic        cpu_ready;
  logic [13:0] rom_addr;
  logic [15:0] rom_rdata;
  logic        illegal_wr;

  int checks = 0;
  int fails  = 0;
  logic [15:0] got_d;
  logic        got_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ROM model echoes its address so the bank bit is visible in read data
  assign rom_rdata = {2'b10, rom_addr};

  cart_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .cart_type(cart_type), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_byte(cpu_byte), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .illegal_wr(illegal_wr)
  );

  function automatic logic [15:0] rom_exp(input logic bank, input logic [15:0] a);
    return {2'b10, bank, a[12:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] ty);
    @(negedge clk);
    rst = 1'b1; cart_type = ty; cpu_rd = 0; cpu_wr = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic access(input logic rd, input logic wr, input logic byt,
                        input logic [15:0] a, input logic [15:0] wd);
    cpu_rd = rd; cpu_wr = wr; cpu_byte = byt; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    got_d = cpu_rdata; got_r = cpu_ready;
    cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic t_reset_state();
    do_reset(4'b0101);
    chk("R4 ready low after reset", {15'd0, cpu_ready}, 16'd0);
    chk("R4 flag low after reset", {15'd0, illegal_wr}, 16'd0);
    access(1, 0, 0, 16'h7FFE, 0);
    chk("R4 bank 0 after reset", got_d, rom_exp(0, 16'h7FFE));
    access(0, 0, 0, 16'h7FFE, 0);
    chk("R11 no ready without strobe", {15'd0, got_r}, 16'd0);
    chk("R11 float without strobe", got_d, 16'hFFFF);
  endtask

  task automatic t_plain_rom();
    do_reset(4'b0001);
    access(1, 0, 0, 16'h6002, 0);
    chk("R1 window ready", {15'd0, got_r}, 16'd1);
    chk("R1 R11 window data", got_d, rom_exp(0, 16'h6002));
    access(1, 0, 0, 16'h5FFE, 0);
    chk("R1 below window ready", {15'd0, got_r}, 16'd0);
    chk("R1 below window float", got_d, 16'hFFFF);
    access(1, 0, 0, 16'h8000, 0);
    chk("R1 above window float", got_d, 16'hFFFF);
    access(0, 1, 1, 16'h6002, 16'h00AA);
    chk("R10 flag set", {15'd0, illegal_wr}, 16'd1);
    access(1, 0, 0, 16'h7002, 0);
    chk("R10 no bank change", got_d, rom_exp(0, 16'h7002));
    chk("R10 flag sticky", {15'd0, illegal_wr}, 16'd1);
  endtask

  task automatic t_no_rom();
    do_reset(4'b0110);
    access(1, 0, 0, 16'h6000, 0);
    chk("R2 no ready on read", {15'd0, got_r}, 16'd0);
    chk("R2 float read", got_d, 16'hFFFF);
    access(0, 1, 1, 16'h6002, 16'h0055);
    chk("R2 no ready on write", {15'd0, got_r}, 16'd0);
    chk("R2 flag untouched", {15'd0, illegal_wr}, 16'd0);
  endtask

  task automatic t_full_bank();
    do_reset(4'b0101);
    access(0, 1, 1, 16'h6002, 16'h0000);
    chk("R3 write ready", {15'd0, got_r}, 16'd1);
    access(1, 0, 0, 16'h6000, 0);
    chk("R3 R6 bank 1 low", got_d, rom_exp(1, 16'h6000));
    access(1, 0, 0, 16'h7ABC, 0);
    chk("R6 bank 1 high", got_d, rom_exp(1, 16'h7ABC));
    chk("R3 no flag", {15'd0, illegal_wr}, 16'd0);
    access(0, 1, 0, 16'h7000, 16'hFFFF);
    access(1, 0, 0, 16'h6000, 0);
    chk("R3 word write picks bank 0", got_d, rom_exp(0, 16'h6000));
    access(1, 1, 1, 16'h6002, 16'h0003);
    chk("R5 read sees old bank", got_d, rom_exp(0, 16'h6002));
    access(1, 0, 0, 16'h6002, 0);
    chk("R5 next read sees new bank", got_d, rom_exp(1, 16'h6002));
  endtask

  task automatic t_half_bank();
    do_reset(4'b1101);
    access(0, 1, 1, 16'h7FF2, 0);
    access(1, 0, 0, 16'h6100, 0);
    chk("R7 lower half fixed", got_d, rom_exp(0, 16'h6100));
    access(1, 0, 0, 16'h7100, 0);
    chk("R7 upper half banked", got_d, rom_exp(1, 16'h7100));
    access(0, 1, 1, 16'h6FF0, 0);
    access(1, 0, 0, 16'h7100, 0);
    chk("R7 lower write switches", got_d, rom_exp(0, 16'h7100));
  endtask

  task automatic t_ram_cart();
    do_reset(4'b0111);
    access(0, 1, 0, 16'h7004, 16'hBEEF);
    chk("R8 RAM write ready", {15'd0, got_r}, 16'd1);
    access(1, 0, 0, 16'h7004, 0);
    chk("R8 word readback", got_d, 16'hBEEF);
    access(0, 1, 1, 16'h7005, 16'h0012);
    access(1, 0, 0, 16'h7004, 0);
    chk("R8 odd byte low lane", got_d, 16'hBE12);
    access(0, 1, 1, 16'h7004, 16'h0034);
    access(1, 0, 1, 16'h7005, 0);
    chk("R8 even byte high lane", got_d, 16'h3412);
    access(0, 1, 0, 16'h7FFE, 16'hA55A);
    access(1, 0, 0, 16'h7FFE, 0);
    chk("R8 last word", got_d, 16'hA55A);
    access(1, 0, 0, 16'h6FFE, 0);
    chk("R9 lower ROM", got_d, rom_exp(0, 16'h6FFE));
    chk("R9 flag clear before", {15'd0, illegal_wr}, 16'd0);
    access(0, 1, 1, 16'h6002, 16'h0077);
    chk("R9 flag set", {15'd0, illegal_wr}, 16'd1);
    access(1, 0, 0, 16'h6002, 0);
    chk("R9 still bank 0", got_d, rom_exp(0, 16'h6002));
    access(1, 0, 0, 16'h7004, 0);
    chk("R9 RAM untouched", got_d, 16'h3412);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_plain_rom();
    t_no_rom();
    t_full_bank();
    t_half_bank();
    t_ram_cart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule